// File: doc/BRIEF.md
# Flash Chip-Select Segment Window Controller

This block keeps one segment register per flash chip select and uses them to split a memory-mapped flash window among the chip selects. Each register holds a start and an end boundary, both counted in 8 MB steps. A write to a segment register does not simply overwrite it. It first passes a series of checks: a fixed start for chip select 0, an optional fixed end for the last chip select, containment in the flash window, and no overlap with the other chip selects. Only a write that passes all of them reaches the register and, through it, the live address decode.

On the access side, a 32-bit address is compared against every enabled segment. The block returns a one-hot chip select and the byte offset of the address from the start of that segment. When no segment holds the address, it raises a miss flag. A sticky status register records the first rejection cause and a flag for a start that is not aligned to the segment size. Software clears these by writing ones.

Top module: `seg_window_ctrl`

## Requirements
- R1: After reset, chip select i reads its default boundaries. The defaults for chip selects 0 to 3 are start/end units 0x40/0x44, 0x44/0x46, 0x46/0x48 and 0x48/0x50. The status register at byte offset 0x50 reads 0.
- R2: The segment register for chip select i sits at byte offset 0x30+4*i. It reads back with the end unit in bits [31:24], the start unit in bits [23:16] and zero in bits [15:0]. One unit is 8 MB, so an address matches a unit when its bits [31:23] equal that unit.
- R3: A segment write whose end and start fields equal the stored ones is ignored. Neither the register nor the status changes, even when the stored value is misaligned.
- R4: On chip select 0, a write whose start differs from the window base unit 0x40 is rejected with cause code 1, and the register keeps its value.
- R5: With the lock parameter set, a write to the last chip select whose end differs from 0x50 is rejected with cause code 2.
- R6: A write whose end is at or below 0x40, or whose start is above 0x50 (window base plus size of 0x10 units), is rejected with cause code 3.
- R7: A write is rejected with cause code 4 when new_start < other_end and new_end > other_start holds for any other chip select. Causes are tested in the order 1, 2, 3, 4.
- R8: A write that passes causes 1 to 3 and has end > start, with start not a multiple of (end - start), sets status bit 8. A write that is accepted in this way still takes effect.
- R9: Status bits [2:0] hold the cause of the first rejection since they were last cleared; later rejections leave them unchanged. Writing the status register with bit 0 set clears bits [2:0]. Writing it with bit 8 set clears bit 8.
- R10: An address inside an enabled segment (end > start) drives the one-hot chip select of that segment and an offset equal to the address minus (start << 23). The miss flag is low in that case.
- R11: An address in no enabled segment drives a zero chip select, a zero offset and a high miss flag. A segment with end <= start matches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Write byte offset |
| wrData | input | 32 | Write data |
| rdAddr | input | 8 | Read byte offset |
| rdData | output | 32 | Read data (combinational) |
| accAddr | input | 32 | Access address to decode |
| accCs | output | 4 | One-hot chip select |
| accOffset | output | 32 | Offset within the selected segment |
| accNoHit | output | 1 | No enabled segment holds the address |

## Verification
A wrong stored boundary shows on two paths. The register readback is wrong in the cycle after the write. The decode is wrong for every address near the moved edge, and it changes in the same cycle as the register. A check that wrongly accepts or rejects a write shows in the next cycle in both the readback and the status cause. It also shows in any later overlap decision that depends on that register. For that reason, random write sequences are compared against a model after every write. Decode probes sit exactly on segment edges, where an off-by-one compare fails at once.

// File: rtl/seg_window_pkg.sv
package seg_window_pkg;
  localparam int CS_IDX_W = 3;

  typedef enum logic [2:0] {
    CAUSE_NONE       = 3'd0,
    CAUSE_CS0_START  = 3'd1,
    CAUSE_END_LOCKED = 3'd2,
    CAUSE_OUT_OF_WIN = 3'd3,
    CAUSE_OVERLAP    = 3'd4
  } rejectCause_e;

  typedef struct packed {
    logic                commit;
    logic [CS_IDX_W-1:0] csIdx;
    logic [7:0]          newStart;
    logic [7:0]          newEnd;
    logic                setCause;
    rejectCause_e        cause;
    logic                setMis;
    logic                clrCause;
    logic                clrMis;
  } segStrobe_t;
endpackage

// File: rtl/seg_window_check.sv
module seg_window_check
  import seg_window_pkg::*;
#(
  parameter int         NUM_CS        = 4,
  parameter logic [7:0] WIN_BASE_U    = 8'h40,
  parameter logic [7:0] WIN_SIZE_U    = 8'h10,
  parameter bit         LOCK_LAST_END = 1'b1,
  parameter logic [7:0] LOCKED_END_U  = 8'h50,
  parameter logic [7:0] SEG_OFF       = 8'h30,
  parameter logic [7:0] STAT_OFF      = 8'h50
) (
  input  logic                       wrEn,
  input  logic [7:0]                 wrAddr,
  input  logic [31:0]                wrData,
  input  logic [NUM_CS-1:0][7:0]     curStart,
  input  logic [NUM_CS-1:0][7:0]     curEnd,
  output segStrobe_t                 strobe
);
  localparam logic [8:0] WIN_TOP_U = {1'b0, WIN_BASE_U} + {1'b0, WIN_SIZE_U};

  logic                segHit;
  logic [7:0]          offDiff;
  logic [CS_IDX_W-1:0] idx;
  logic [7:0]          newStart, newEnd, oldStart, oldEnd, segSize, divisor;
  logic                sameVal, rejCs0, rejLock, rejWin, rejOvl, misal;

  always_comb begin
    offDiff  = wrAddr - SEG_OFF;
    idx      = offDiff[CS_IDX_W+1:2];
    segHit   = wrEn && (wrAddr[1:0] == 2'b00) && (wrAddr >= SEG_OFF) &&
               ({1'b0, offDiff} < 9'(4 * NUM_CS));
    newStart = wrData[23:16];
    newEnd   = wrData[31:24];
    oldStart = '0;
    oldEnd   = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (idx == CS_IDX_W'(i)) begin
        oldStart = curStart[i];
        oldEnd   = curEnd[i];
      end
    end
    sameVal = (newStart == oldStart) && (newEnd == oldEnd);
    rejCs0  = (idx == '0) && (newStart != WIN_BASE_U);
    rejLock = LOCK_LAST_END && (idx == CS_IDX_W'(NUM_CS - 1)) && (newEnd != LOCKED_END_U);
    rejWin  = (newEnd <= WIN_BASE_U) || ({1'b0, newStart} > WIN_TOP_U);
    rejOvl  = 1'b0;
    for (int j = 0; j < NUM_CS; j++) begin
      if (idx != CS_IDX_W'(j) && newStart < curEnd[j] && newEnd > curStart[j])
        rejOvl = 1'b1;
    end
    segSize = newEnd - newStart;
    divisor = (newEnd > newStart) ? segSize : 8'd1;
    misal   = (newEnd > newStart) && ((newStart % divisor) != 8'd0);

    strobe          = '0;
    strobe.csIdx    = idx;
    strobe.newStart = newStart;
    strobe.newEnd   = newEnd;
    strobe.cause    = CAUSE_NONE;
    if (segHit && !sameVal) begin
      if (rejCs0)       strobe.cause = CAUSE_CS0_START;
      else if (rejLock) strobe.cause = CAUSE_END_LOCKED;
      else if (rejWin)  strobe.cause = CAUSE_OUT_OF_WIN;
      else begin
        strobe.setMis = misal;
        if (rejOvl) strobe.cause = CAUSE_OVERLAP;
      end
      strobe.setCause = (strobe.cause != CAUSE_NONE);
      strobe.commit   = (strobe.cause == CAUSE_NONE);
    end
    if (wrEn && wrAddr == STAT_OFF) begin
      strobe.clrCause = wrData[0];
      strobe.clrMis   = wrData[8];
    end
  end
endmodule

// File: rtl/seg_window_dp.sv
module seg_window_dp
  import seg_window_pkg::*;
#(
  parameter int                  NUM_CS    = 4,
  parameter logic [NUM_CS*8-1:0] DEF_START = 32'h48_46_44_40,
  parameter logic [NUM_CS*8-1:0] DEF_END   = 32'h50_48_46_44,
  parameter logic [7:0]          SEG_OFF   = 8'h30,
  parameter logic [7:0]          STAT_OFF  = 8'h50
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  segStrobe_t             strobe,
  input  logic [7:0]             rdAddr,
  output logic [31:0]            rdData,
  input  logic [31:0]            accAddr,
  output logic [NUM_CS-1:0]      accCs,
  output logic [31:0]            accOffset,
  output logic                   accNoHit,
  output logic [NUM_CS-1:0][7:0] curStart,
  output logic [NUM_CS-1:0][7:0] curEnd,
  output logic [2:0]             causeQ,
  output logic                   misQ
);
  logic [NUM_CS-1:0] segMatch;
  logic [8:0]        accUnit;

  assign accUnit = accAddr[31:23];

  for (genvar g = 0; g < NUM_CS; g++) begin : gSeg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        curStart[g] <= DEF_START[g*8 +: 8];
        curEnd[g]   <= DEF_END[g*8 +: 8];
      end else if (strobe.commit && strobe.csIdx == CS_IDX_W'(g)) begin
        curStart[g] <= strobe.newStart;
        curEnd[g]   <= strobe.newEnd;
      end
    end
    assign segMatch[g] = (curEnd[g] > curStart[g]) &&
                         (accUnit >= {1'b0, curStart[g]}) &&
                         (accUnit <  {1'b0, curEnd[g]});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeQ <= '0;
      misQ   <= 1'b0;
    end else begin
      if (strobe.clrCause)                      causeQ <= '0;
      else if (strobe.setCause && causeQ == '0) causeQ <= strobe.cause;
      if (strobe.clrMis)      misQ <= 1'b0;
      else if (strobe.setMis) misQ <= 1'b1;
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (rdAddr == SEG_OFF + 8'(4 * i)) rdData = {curEnd[i], curStart[i], 16'h0000};
    end
    if (rdAddr == STAT_OFF) rdData = {23'd0, misQ, 5'd0, causeQ};
  end

  always_comb begin
    accCs     = '0;
    accOffset = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (segMatch[i]) begin
        accCs     = '0;
        accCs[i]  = 1'b1;
        accOffset = accAddr - {1'b0, curStart[i], 23'd0};
      end
    end
    accNoHit = (segMatch == '0);
  end
endmodule

// File: rtl/seg_window_ctrl.sv
module seg_window_ctrl
  import seg_window_pkg::*;
#(
  parameter int                  NUM_CS        = 4,
  parameter logic [7:0]          WIN_BASE_U    = 8'h40,
  parameter logic [7:0]          WIN_SIZE_U    = 8'h10,
  parameter bit                  LOCK_LAST_END = 1'b1,
  parameter logic [NUM_CS*8-1:0] DEF_START     = 32'h48_46_44_40,
  parameter logic [NUM_CS*8-1:0] DEF_END       = 32'h50_48_46_44,
  parameter logic [7:0]          SEG_OFF       = 8'h30,
  parameter logic [7:0]          STAT_OFF      = 8'h50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [7:0]        wrAddr,
  input  logic [31:0]       wrData,
  input  logic [7:0]        rdAddr,
  output logic [31:0]       rdData,
  input  logic [31:0]       accAddr,
  output logic [NUM_CS-1:0] accCs,
  output logic [31:0]       accOffset,
  output logic              accNoHit
);
  localparam logic [7:0] LOCKED_END_U = DEF_END[(NUM_CS-1)*8 +: 8];

  segStrobe_t                strobe;
  logic [NUM_CS-1:0][7:0]    curStart, curEnd;
  logic [2:0]                causeQ;
  logic                      misQ;

  seg_window_check #(
    .NUM_CS(NUM_CS), .WIN_BASE_U(WIN_BASE_U), .WIN_SIZE_U(WIN_SIZE_U),
    .LOCK_LAST_END(LOCK_LAST_END), .LOCKED_END_U(LOCKED_END_U),
    .SEG_OFF(SEG_OFF), .STAT_OFF(STAT_OFF)
  ) uCheck (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .curStart(curStart), .curEnd(curEnd), .strobe(strobe)
  );

  seg_window_dp #(
    .NUM_CS(NUM_CS), .DEF_START(DEF_START), .DEF_END(DEF_END),
    .SEG_OFF(SEG_OFF), .STAT_OFF(STAT_OFF)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rdAddr(rdAddr), .rdData(rdData),
    .accAddr(accAddr), .accCs(accCs), .accOffset(accOffset), .accNoHit(accNoHit),
    .curStart(curStart), .curEnd(curEnd), .causeQ(causeQ), .misQ(misQ)
  );
endmodule

// File: rtl/seg_window_props.sv
module seg_window_props #(
  parameter int         NUM_CS        = 4,
  parameter logic [7:0] WIN_BASE_U    = 8'h40,
  parameter bit         LOCK_LAST_END = 1'b1,
  parameter logic [7:0] SEG_OFF       = 8'h30,
  parameter logic [7:0] STAT_OFF      = 8'h50
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   wrEn,
  input logic [7:0]             wrAddr,
  input logic [31:0]            wrData,
  input logic [7:0]             rdAddr,
  input logic [31:0]            rdData,
  input logic [NUM_CS-1:0]      accCs,
  input logic                   accNoHit,
  input logic [NUM_CS-1:0][7:0] curStart,
  input logic [NUM_CS-1:0][7:0] curEnd,
  input logic [2:0]             causeQ
);
  logic sameWrite, rdIsSeg;

  always_comb begin
    sameWrite = 1'b0;
    rdIsSeg   = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (wrEn && wrAddr == SEG_OFF + 8'(4 * i) &&
          wrData[31:24] == curEnd[i] && wrData[23:16] == curStart[i])
        sameWrite = 1'b1;
      if (rdAddr == SEG_OFF + 8'(4 * i)) rdIsSeg = 1'b1;
    end
  end

  // R11
  miss_no_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    accNoHit |-> (accCs == '0));

  // R10
  hit_single_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accNoHit |-> ($countones(accCs) == 1));

  // R4
  cs0_start_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    curStart[0] == WIN_BASE_U);

  // R2
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdIsSeg |-> (rdData[15:0] == 16'h0000));

  // R3
  same_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    sameWrite |=> ($stable(curStart) && $stable(curEnd) && $stable(causeQ)));

  // R9
  cause_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == STAT_OFF && wrData[0]) |=> (causeQ == 3'd0));

  if (LOCK_LAST_END) begin : gLock
    // R5
    last_end_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
      rstN |=> $stable(curEnd[NUM_CS-1]));
  end
endmodule

bind seg_window_ctrl seg_window_props #(
  .NUM_CS(NUM_CS), .WIN_BASE_U(WIN_BASE_U), .LOCK_LAST_END(LOCK_LAST_END),
  .SEG_OFF(SEG_OFF), .STAT_OFF(STAT_OFF)
) uProps (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdAddr(rdAddr), .rdData(rdData), .accCs(accCs), .accNoHit(accNoHit),
  .curStart(curStart), .curEnd(curEnd), .causeQ(causeQ)
);

// File: tb/seg_window_ctrl_test.sv
module seg_window_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [31:0] accAddr = '0;
  logic [3:0]  accCs;
  logic [31:0] accOffset;
  logic        accNoHit;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int refStart[4];
  int refEnd[4];
  int refCause;
  int refMis;

  always #5 clk = ~clk;

  seg_window_ctrl uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .accAddr(accAddr), .accCs(accCs),
    .accOffset(accOffset), .accNoHit(accNoHit)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic refSeg(int cs, int s, int e);
    int code;
    if (s == refStart[cs] && e == refEnd[cs]) return;
    code = 0;
    if (cs == 0 && s != 'h40) code = 1;
    else if (cs == 3 && e != 'h50) code = 2;
    else if (e <= 'h40 || s > 'h50) code = 3;
    else begin
      if (e > s && (s % (e - s)) != 0) refMis = 1;
      for (int j = 0; j < 4; j++)
        if (j != cs && s < refEnd[j] && e > refStart[j]) code = 4;
    end
    if (code != 0) begin
      if (refCause == 0) refCause = code;
    end else begin
      refStart[cs] = s;
      refEnd[cs] = e;
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (a == 8'h50) begin
      if (d[0]) refCause = 0;
      if (d[8]) refMis = 0;
    end else if (a >= 8'h30 && a <= 8'h3C && a[1:0] == 2'b00) begin
      refSeg((a - 8'h30) >> 2, int'(d[23:16]), int'(d[31:24]));
    end
  endtask

  task automatic segWrite(int cs, int s, int e);
    busWrite(8'(8'h30 + 4 * cs), {8'(e), 8'(s), 16'h0000});
  endtask

  task automatic readCheck(string req, logic [7:0] a, logic [31:0] exp);
    rdAddr = a;
    #1;
    check(req, rdData, exp);
  endtask

  task automatic checkAll(string req);
    for (int i = 0; i < 4; i++)
      readCheck(req, 8'(8'h30 + 4 * i), {8'(refEnd[i]), 8'(refStart[i]), 16'h0000});
    readCheck(req, 8'h50, {23'd0, refMis[0], 5'd0, 3'(refCause)});
  endtask

  task automatic decodeCheck(string req, logic [31:0] a);
    logic [3:0]  expCs;
    logic [31:0] expOff;
    int unit;
    expCs = '0;
    expOff = '0;
    unit = int'(a[31:23]);
    for (int i = 0; i < 4; i++) begin
      if (expCs == '0 && refEnd[i] > refStart[i] && unit >= refStart[i] && unit < refEnd[i]) begin
        expCs[i] = 1'b1;
        expOff = a - (32'(refStart[i]) << 23);
      end
    end
    accAddr = a;
    #1;
    check(req, {31'd0, accNoHit}, {31'd0, expCs == '0});
    check(req, {28'd0, accCs}, {28'd0, expCs});
    check(req, accOffset, expOff);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EC7_0A11));
    refStart = '{'h40, 'h44, 'h46, 'h48};
    refEnd   = '{'h44, 'h46, 'h48, 'h50};
    refCause = 0;
    refMis = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkAll("R1");
    // R10 / R11 edges of the default map
    decodeCheck("R10", 32'h2234_5678);
    decodeCheck("R10", 32'h27FF_FFFF);
    decodeCheck("R10", 32'h2000_0000);
    decodeCheck("R11", 32'h1FFF_FFFF);
    decodeCheck("R11", 32'h2800_0000);
    // R4 cs0 start fixed
    segWrite(0, 'h41, 'h44);
    checkAll("R4");
    // R9 first cause sticks, then clear
    segWrite(2, 'h30, 'h38);
    checkAll("R9");
    busWrite(8'h50, 32'h1);
    checkAll("R9");
    // R5 locked last end
    segWrite(3, 'h48, 'h4F);
    checkAll("R5");
    busWrite(8'h50, 32'h1);
    // R6 start above window
    segWrite(2, 'h51, 'h55);
    checkAll("R6");
    busWrite(8'h50, 32'h1);
    // R7 overlap with cs1
    segWrite(2, 'h45, 'h48);
    checkAll("R7");
    busWrite(8'h50, 32'h1);
    // R11 zero-size segment disables
    segWrite(2, 'h47, 'h47);
    checkAll("R11");
    decodeCheck("R11", 32'h2300_0000);
    // R8 misaligned but accepted
    segWrite(1, 'h45, 'h47);
    checkAll("R8");
    readCheck("R2", 8'h34, 32'h4745_0000);
    decodeCheck("R11", 32'h2200_0000);
    decodeCheck("R10", 32'h2280_0004);
    // R3 identical write ignored, low bits dropped
    busWrite(8'h50, 32'h101);
    busWrite(8'h34, 32'h4745_0000);
    checkAll("R3");
    busWrite(8'h34, 32'h4745_ABCD);
    checkAll("R3");
    readCheck("R2", 8'h34, 32'h4745_0000);
    // R9 misalign flag clear needs bit 8
    segWrite(1, 'h45, 'h46);
    segWrite(1, 'h45, 'h47);
    busWrite(8'h50, 32'h1);
    checkAll("R9");
    busWrite(8'h50, 32'h100);
    checkAll("R9");

    // random mix: R2 R4 R5 R6 R7 R8 R9 R10 R11
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 6) begin
        segWrite(int'($urandom_range(0, 3)), int'($urandom_range('h3C, 'h52)),
                 int'($urandom_range('h3C, 'h54)));
        checkAll("R7");
      end else if (op < 7) begin
        busWrite(8'h50, $urandom() & 32'h101);
        checkAll("R9");
      end else begin
        decodeCheck("R10", {1'b0, 8'($urandom_range('h3C, 'h54)), 23'($urandom())});
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule